// File: doc/BRIEF.md
# Dual-Lane Serial ADC Read Controller

This block sits on the host side of an eight-channel converter that delivers its 18-bit results on two serial data lanes at once. It drives an active-low chip select and a serial clock derived from the system clock. With one frame of 72 serial clock periods it collects four words from each lane: channels 0 to 3 from lane A and channels 4 to 7 from lane B. At the end of the frame it presents all eight words together with a one-cycle valid strobe. During the first word the converter raises a first-data flag. If that flag is missing, the controller reports an alignment error with the results.

A frame starts on a software request or on the falling edge of the converter's busy signal, which is the moment fresh results land in its output registers. A frame may run while busy is high. A busy falling edge that arrives in the middle of a frame makes the controller abandon that frame, release chip select and read again from the start. The new frame therefore never spans the register update. A request that arrives while a frame is running is remembered and served once the frame ends.

Top module: `adc_dual_lane_reader`

## Requirements
- R1: Out of reset and whenever no frame is running, `cs_n` is 1, `sclk` is 1 and `result_valid` is 0.
- R2: A frame holds `cs_n` at 0 for exactly 72 `sclk` periods. `sclk` starts high and then spends SCLK_DIV/2 system clocks low and SCLK_DIV/2 high in turn. Each lane is sampled as `sclk` falls, and the first sample is the most significant bit of the first word.
- R3: `results[c*18 +: 18]` holds channel c. Channels 0..3 are the first to fourth words of lane A, and channels 4..7 are the first to fourth words of lane B.
- R4: At the clock edge where a finished frame raises `cs_n`, `result_valid` pulses high for one cycle. `results` and `align_err` change only at that edge and hold until the next finished frame.
- R5: `align_err` is 1 when `first_flag` was sampled low at any of the first 18 `sclk` falling edges of the frame, and 0 otherwise.
- R6: With no frame running, a high `start_req` or a busy falling edge (`busy` 1 at one clock edge, 0 at the next) drives `cs_n` to 0 at that same edge.
- R7: A frame runs to completion while `busy` stays high. A busy falling edge during a frame drives `cs_n` to 1 at that edge without a valid pulse, and a new frame starts at the following edge.
- R8: A `start_req` seen during a frame is held. A new frame begins one clock after the frame ends, and several such requests produce only one extra frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request for a read frame |
| busy | input | 1 | Converter busy indicator, synchronous to clk |
| sdata_a | input | 1 | Serial data, lane A (channels 0..3) |
| sdata_b | input | 1 | Serial data, lane B (channels 4..7) |
| first_flag | input | 1 | High while the first word is on lane A |
| cs_n | output | 1 | Active-low chip select |
| sclk | output | 1 | Serial clock, idles high |
| result_valid | output | 1 | One-cycle strobe for new results |
| align_err | output | 1 | First-data flag missing in the last frame |
| results | output | 144 | Eight 18-bit channel words, channel c at bits c*18+17:c*18 |

## Verification
A converter model shifts one bit out on each serial clock rise. A behavioural timeline model predicts `cs_n`, `sclk` and `result_valid` for every clock, and results are compared at each strobe.

Several word patterns are used. A set of distinct words exposes swapped channels or lanes, and words of all ones, all zeros and alternating bits expose shifts by one position and a reversed bit order. Separate cases start frames by request, by a busy fall in idle, and by a frame run entirely under busy high. They also cover a busy fall in mid-frame, which must abort the frame and restart it, and a request arriving mid-frame, which must give exactly one queued frame. Running one frame with the first-data flag held low and then a correct frame shows that the error flag both sets and clears.

// File: rtl/adc_dual_lane_reader.sv
module adc_dual_lane_reader #(
  parameter int WORD_BITS      = 18,
  parameter int WORDS_PER_LANE = 4,
  parameter int SCLK_DIV       = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_req,
  input  logic busy,
  input  logic sdata_a,
  input  logic sdata_b,
  input  logic first_flag,
  output logic cs_n,
  output logic sclk,
  output logic result_valid,
  output logic align_err,
  output logic [2*WORDS_PER_LANE*WORD_BITS-1:0] results
);

  localparam int HALF  = (SCLK_DIV < 2) ? 1 : SCLK_DIV / 2;
  localparam int FRAME = WORD_BITS * WORDS_PER_LANE;
  localparam int NCH   = 2 * WORDS_PER_LANE;
  localparam int CW    = $clog2(FRAME);
  localparam int DW    = (HALF > 1) ? $clog2(HALF) : 1;

  logic             busy_q;
  logic             pend;
  logic             err_acc;
  logic [DW-1:0]    div_cnt;
  logic [CW-1:0]    bit_cnt;
  logic [FRAME-1:0] sh_a, sh_b;
  logic [NCH*WORD_BITS-1:0] packed_words;

  wire busy_fall = busy_q & ~busy;
  wire half_done = (div_cnt == DW'(HALF - 1));
  wire last_bit  = (bit_cnt == CW'(FRAME - 1));
  wire running   = ~cs_n & ~busy_fall;
  wire start_now = cs_n & (pend | start_req | busy_fall);
  wire capture   = running & half_done & sclk;
  wire finish    = running & half_done & ~sclk & last_bit;
  wire in_first  = (bit_cnt < CW'(WORD_BITS));

  always_ff @(posedge clk) busy_q <= busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_n         <= 1'b1;
      sclk         <= 1'b1;
      pend         <= 1'b0;
      err_acc      <= 1'b0;
      div_cnt      <= '0;
      bit_cnt      <= '0;
      result_valid <= 1'b0;
    end else begin
      result_valid <= 1'b0;
      if (cs_n) begin
        if (start_now) begin
          cs_n    <= 1'b0;
          sclk    <= 1'b1;
          pend    <= 1'b0;
          err_acc <= 1'b0;
          div_cnt <= '0;
          bit_cnt <= '0;
        end
      end else if (busy_fall) begin
        cs_n <= 1'b1;
        sclk <= 1'b1;
        pend <= 1'b1;
      end else begin
        if (start_req) pend <= 1'b1;
        if (half_done) begin
          div_cnt <= '0;
          if (sclk) begin
            sclk <= 1'b0;
            if (in_first && !first_flag) err_acc <= 1'b1;
          end else if (last_bit) begin
            cs_n         <= 1'b1;
            sclk         <= 1'b1;
            result_valid <= 1'b1;
          end else begin
            sclk    <= 1'b1;
            bit_cnt <= bit_cnt + 1'b1;
          end
        end else begin
          div_cnt <= div_cnt + 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (capture) begin
      sh_a <= {sh_a[FRAME-2:0], sdata_a};
      sh_b <= {sh_b[FRAME-2:0], sdata_b};
    end
  end

  for (genvar c = 0; c < WORDS_PER_LANE; c++) begin : g_chan
    assign packed_words[c*WORD_BITS +: WORD_BITS] =
      sh_a[(WORDS_PER_LANE-1-c)*WORD_BITS +: WORD_BITS];
    assign packed_words[(c+WORDS_PER_LANE)*WORD_BITS +: WORD_BITS] =
      sh_b[(WORDS_PER_LANE-1-c)*WORD_BITS +: WORD_BITS];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      results   <= '0;
      align_err <= 1'b0;
    end else if (finish) begin
      results   <= packed_words;
      align_err <= err_acc;
    end
  end

  p_idle_sclk_high_r1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> sclk);
  p_sclk_fall_in_frame_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sclk) |-> !cs_n);
  p_valid_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |=> !result_valid);
  p_valid_at_frame_end_r4: assert property (@(posedge clk) disable iff (!rst_n)
    result_valid |-> (cs_n && $past(!cs_n)));
  p_err_changes_with_valid_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(align_err) |-> result_valid);
  p_request_starts_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cs_n && start_req) |=> !cs_n);
  p_abort_on_busy_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!cs_n && $fell(busy)) |=> (cs_n && !result_valid));

endmodule

// File: tb/adc_dual_lane_reader_bench.sv
module adc_dual_lane_reader_bench;
  localparam int WB = 18, WPL = 4, DIV = 4;
  localparam int HALF = DIV / 2;
  localparam int FRAME = WB * WPL;
  localparam int FRAME_CYC = 2 * FRAME * HALF;
  localparam int RW = 2 * WPL * WB;

  logic clk = 0, rst_n = 0, start_req = 0, busy = 0;
  logic sdata_a, sdata_b, first_flag;
  logic cs_n, sclk, result_valid, align_err;
  logic [RW-1:0] results;

  always #10 clk = ~clk;

  adc_dual_lane_reader #(.WORD_BITS(WB), .WORDS_PER_LANE(WPL), .SCLK_DIV(DIV)) u_adc_dual_lane_reader (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .busy(busy),
    .sdata_a(sdata_a), .sdata_b(sdata_b), .first_flag(first_flag),
    .cs_n(cs_n), .sclk(sclk), .result_valid(result_valid),
    .align_err(align_err), .results(results));

  // converter model
  logic [WB-1:0] wa [WPL];
  logic [WB-1:0] wb [WPL];
  logic flag_bad = 0;
  int idx = 0;
  always @(negedge cs_n) idx = 0;
  always @(posedge sclk) if (!cs_n) idx = idx + 1;
  always_comb begin
    sdata_a = 1'b0; sdata_b = 1'b0;
    if (idx < FRAME) begin
      sdata_a = wa[idx / WB][WB-1-(idx % WB)];
      sdata_b = wb[idx / WB][WB-1-(idx % WB)];
    end
    first_flag = !cs_n && (idx < WB) && !flag_bad;
  end

  int n_checks = 0, n_fail = 0, n_valid = 0, cyc = 0;
  bit cmp_on = 0;

  task automatic check(input string req, input logic [RW-1:0] act, input logic [RW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [RW-1:0] exp_results();
    logic [RW-1:0] r;
    for (int c = 0; c < WPL; c++) begin
      r[c*WB +: WB] = wa[c];
      r[(c+WPL)*WB +: WB] = wb[c];
    end
    return r;
  endfunction

  // timeline reference model
  bit m_act = 0, m_pend = 0, m_valid = 0, m_prev_busy = 0, fall;
  int m_t = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_act = 0; m_pend = 0; m_valid = 0; m_t = 0;
    end else begin
      fall = m_prev_busy && !busy;
      m_valid = 0;
      if (!m_act) begin
        if (m_pend || start_req || fall) begin m_act = 1; m_t = 0; m_pend = 0; end
      end else if (fall) begin
        m_act = 0; m_pend = 1;
      end else begin
        if (start_req) m_pend = 1;
        m_t++;
        if (m_t == FRAME_CYC) begin m_act = 0; m_valid = 1; end
      end
    end
    m_prev_busy = busy;
  end

  always @(negedge clk) begin
    if (rst_n && cmp_on) begin
      check("R2 frame cs_n/sclk timeline",
            RW'({cs_n, sclk}),
            RW'({!m_act, m_act ? ((m_t / HALF) % 2 == 0) : 1'b1}));
      check("R4 valid strobe timing", RW'(result_valid), RW'(m_valid));
      if (result_valid) n_valid++;
      if (m_valid) begin
        check("R3 channel/lane mapping, R2 MSB first", results, exp_results());
        check("R5 alignment error flag", RW'(align_err), RW'(flag_bad));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  task automatic pulse_req();
    @(negedge clk) start_req = 1;
    @(negedge clk) start_req = 0;
  endtask

  task automatic settle();
    repeat (FRAME_CYC + 20) @(negedge clk);
  endtask

  task automatic expect_valids(input string req, input int exp);
    check(req, RW'(n_valid), RW'(exp));
    n_valid = 0;
  endtask

  initial begin
    for (int c = 0; c < WPL; c++) begin
      wa[c] = WB'(18'h01234 + c * 18'h11111);
      wb[c] = WB'(18'h3A5C1 - c * 18'h0F0F3);
    end
    repeat (4) @(negedge clk);
    check("R1 reset outputs", RW'({cs_n, sclk, result_valid}), RW'(3'b110));
    rst_n = 1;
    cmp_on = 1;
    repeat (3) @(negedge clk);
    check("R1 idle outputs", RW'({cs_n, sclk, result_valid}), RW'(3'b110));

    pulse_req(); settle();
    expect_valids("R6 request starts one frame", 1);

    wa[0] = '1; wa[1] = '0; wa[2] = 18'h2AAAA; wa[3] = 18'h15555;
    wb[0] = 18'h20001; wb[1] = 18'h15555; wb[2] = '0; wb[3] = '1;
    pulse_req(); settle();
    expect_valids("R2 edge patterns frame", 1);

    @(negedge clk) busy = 1;
    repeat (5) @(negedge clk);
    busy = 0;
    settle();
    expect_valids("R6 busy fall starts one frame", 1);

    busy = 1;
    pulse_req(); settle();
    busy = 0;
    settle();
    expect_valids("R7 frame under busy high plus busy-fall frame", 2);

    busy = 1;
    pulse_req();
    repeat (60) @(negedge clk);
    busy = 0;
    settle();
    expect_valids("R7 aborted frame restarts once", 1);

    pulse_req();
    repeat (40) @(negedge clk);
    pulse_req();
    repeat (30) @(negedge clk);
    pulse_req();
    settle(); settle();
    expect_valids("R8 held requests give one extra frame", 2);

    flag_bad = 1;
    pulse_req(); settle();
    expect_valids("R5 frame with missing flag", 1);
    check("R5 error held after frame", RW'(align_err), RW'(1));
    flag_bad = 0;
    pulse_req(); settle();
    check("R5 error cleared by good frame", RW'(align_err), RW'(0));
    check("R4 results held after strobe", results, exp_results());
    expect_valids("R5 good frame", 1);

    cmp_on = 0;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule